// File: doc/BRIEF.md
# Indexed Register Move with Packed Indices

This block runs an indexed gather move inside its own register file. A command names a destination register, a base register number, an index-source register, a 4-bit function code and two lengths (vector length and sub-vector length). For each step the block picks an index out of the index-source registers, adds it to the base register number, and copies the register found there into the next destination register. One move completes per clock cycle, and each write can be read by the following step.

The function code decides how indices are stored. Bits [3:2] give the index width: code 0 keeps one full-width index per register, and codes 1, 2 and 3 pack 8-, 16- or 32-bit indices side by side, so one index register can supply several steps. Bit 1 selects the loop mode. In flat mode every step takes its own index and the offsets run across the whole vector. In group mode, meant for transposition, only the first sub-vector-length indices are used, and each outer group adds them to its own base. Bit 0 must be 1, and code 0b0000 is kept for a different move. A load port and a read-back port give the surrounding logic access to the register file.

Top module: `packed_index_mover`

## Requirements
- R1: After reset, `busy`, `done` and `err` are all 0.
- R2: While the block is idle, `load_en` writes `load_data` to register `load_addr`. `peek_data` shows the contents of register `peek_addr` one clock after the address is applied.
- R3: With index width code 0 in flat mode, step k (0 ≤ k < vl·subvl) writes register `cmd_dst`+k with the contents of register `cmd_base`+X, where X is the whole 64-bit value of register `cmd_idx`+k.
- R4: With index width code 1, 2 or 3 (w = 8, 16 or 32 bits, p = 64/w fields per register), index element e is bits [(e mod p)·w +: w] of register `cmd_idx`+⌊e/p⌋, zero-extended. Fields start at the least significant end.
- R5: In group mode (`cmd_fn[1]`=1), step k = i·subvl+j writes register `cmd_dst`+k with register `cmd_base`+i·subvl+X, where X is index element j. The same subvl indices serve every outer group i.
- R6: A command accepted with vl·subvl = N > 0 performs exactly one move per cycle. `busy` is high while moves run, and `done` pulses for one cycle on the N-th clock edge after the accepting edge.
- R7: A register written by one step holds its new value when a later step reads it.
- R8: If the source, destination or index register number of a step is 32 or more, that step writes nothing and `err` is set. The remaining steps still run. `err` is cleared by the next accepted command.
- R9: A command with `cmd_fn[0]`=0 is rejected. `done` pulses on the clock after acceptance, `err` is set, and no register is written.
- R10: A command with `cmd_vl`=0 or `cmd_subvl`=0 finishes with a `done` pulse on the clock after acceptance. It writes nothing and leaves `err` at 0.
- R11: While `busy` is high, `start` and `load_en` are ignored. No register changes through the load port, and no second command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Register file load strobe (ignored while busy) |
| load_addr | input | 5 | Register number to load |
| load_data | input | 64 | Value to load |
| peek_addr | input | 5 | Register number to read back |
| peek_data | output | 64 | Registered read-back data |
| start | input | 1 | Command strobe, accepted when idle |
| cmd_dst | input | 5 | First destination register |
| cmd_base | input | 5 | Base register number for sources |
| cmd_idx | input | 5 | First index-source register |
| cmd_fn | input | 4 | [3:2] index width, [1] group mode, [0] must be 1 |
| cmd_vl | input | 4 | Vector length (outer count) |
| cmd_subvl | input | 3 | Sub-vector length (inner count) |
| busy | output | 1 | Moves in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error for the last command |

## Verification
The assertions check the sequencer on every cycle: the step counter advances by one per busy cycle, the inner counter stays below the sub-vector length, `done` never overlaps `busy`, and the drop of `busy` comes with `done`. They also check that rejected or empty commands finish on the next clock, and that `err` rises only while a command is accepted or running. The bench scenarios are the only check on the moved data. They cover the field position picked at each index width, the group-mode offsets, visibility of a write to the next step, suppression of out-of-range writes, and that loads and starts arriving during a run change nothing.

// File: rtl/pim_pkg.sv
package pim_pkg;

  typedef enum logic [1:0] {
    IW_FULL = 2'd0,
    IW_8    = 2'd1,
    IW_16   = 2'd2,
    IW_32   = 2'd3
  } idx_width_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/pim_regfile.sv
module pim_regfile #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   idx_addr,
  output logic [XLEN-1:0] idx_data,
  input  logic [AW-1:0]   src_addr,
  output logic [XLEN-1:0] src_data,
  input  logic [AW-1:0]   peek_addr,
  output logic [XLEN-1:0] peek_data
);

  logic [XLEN-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // move path reads asynchronously so one move completes per cycle
  assign idx_data = mem[idx_addr];
  assign src_data = mem[src_addr];

  // read-back port is registered
  always_ff @(posedge clk) begin
    peek_data <= mem[peek_addr];
  end

endmodule

// File: rtl/pim_index_extract.sv
module pim_index_extract
  import pim_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CNT_W = 7
) (
  input  logic [XLEN-1:0]  word,
  input  logic [CNT_W-1:0] elem,
  input  logic [1:0]       wcode,
  output logic [XLEN-1:0]  idx_val,
  output logic [CNT_W-1:0] reg_off
);

  logic [XLEN-1:0]  cand_val [4];
  logic [CNT_W-1:0] cand_off [4];

  // full width: one index per register
  assign cand_val[0] = word;
  assign cand_off[0] = elem;

  for (genvar c = 1; c < 4; c++) begin : g_packed
    localparam int FW   = 8 << (c - 1);
    localparam int PER  = XLEN / FW;
    localparam int LPER = $clog2(PER);
    logic [CNT_W-1:0] field;
    logic [XLEN-1:0]  shifted;
    assign field       = elem & CNT_W'(PER - 1);
    assign shifted     = word >> (int'(field) * FW);
    assign cand_val[c] = XLEN'(shifted[FW-1:0]);
    assign cand_off[c] = elem >> LPER;
  end

  always_comb begin
    case (idx_width_e'(wcode))
      IW_8:    begin idx_val = cand_val[1]; reg_off = cand_off[1]; end
      IW_16:   begin idx_val = cand_val[2]; reg_off = cand_off[2]; end
      IW_32:   begin idx_val = cand_val[3]; reg_off = cand_off[3]; end
      default: begin idx_val = cand_val[0]; reg_off = cand_off[0]; end
    endcase
  end

endmodule

// File: rtl/pim_sequencer.sv
module pim_sequencer
  import pim_pkg::*;
#(
  parameter int VL_W  = 4,
  parameter int SV_W  = 3,
  parameter int CNT_W = VL_W + SV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       fn,
  input  logic [VL_W-1:0]  vl,
  input  logic [SV_W-1:0]  subvl,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             reject,
  output logic             sub_mode,
  output logic [1:0]       wcode,
  output logic [VL_W-1:0]  outer,
  output logic [SV_W-1:0]  inner,
  output logic [CNT_W-1:0] step,
  output logic [SV_W-1:0]  sv_len
);

  seq_state_e      state;
  logic [VL_W-1:0] vl_q;
  logic            last;
  logic            empty;

  assign busy   = (state == SEQ_RUN);
  assign accept = start && !busy;
  assign reject = accept && !fn[0];
  assign empty  = (vl == '0) || (subvl == '0);
  assign last   = (outer == vl_q - 1'b1) && (inner == sv_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      done     <= 1'b0;
      sub_mode <= 1'b0;
      wcode    <= 2'd0;
      vl_q     <= '0;
      sv_len   <= '0;
      outer    <= '0;
      inner    <= '0;
      step     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        sub_mode <= fn[1];
        wcode    <= fn[3:2];
        vl_q     <= vl;
        sv_len   <= subvl;
        outer    <= '0;
        inner    <= '0;
        step     <= '0;
        if (!fn[0] || empty) done  <= 1'b1;
        else                 state <= SEQ_RUN;
      end else if (busy) begin
        if (last) begin
          state <= SEQ_IDLE;
          done  <= 1'b1;
        end else begin
          step <= step + 1'b1;
          if (inner == sv_len - 1'b1) begin
            inner <= '0;
            outer <= outer + 1'b1;
          end else begin
            inner <= inner + 1'b1;
          end
        end
      end
    end
  end

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_step_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (step == CNT_W'($past(step) + 1'b1)));

  assert_fall_signals_done_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_inner_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (inner < sv_len));

  assert_reject_fast_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !fn[0]) |=> (done && !busy));

  assert_empty_fast_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && fn[0] && ((vl == '0) || (subvl == '0))) |=> (done && !busy));

endmodule

// File: rtl/packed_index_mover.sv
module packed_index_mover #(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int VL_W  = 4,
  parameter int SV_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic [$clog2(NREGS)-1:0] load_addr,
  input  logic [XLEN-1:0]          load_data,
  input  logic [$clog2(NREGS)-1:0] peek_addr,
  output logic [XLEN-1:0]          peek_data,
  input  logic                     start,
  input  logic [$clog2(NREGS)-1:0] cmd_dst,
  input  logic [$clog2(NREGS)-1:0] cmd_base,
  input  logic [$clog2(NREGS)-1:0] cmd_idx,
  input  logic [3:0]               cmd_fn,
  input  logic [VL_W-1:0]          cmd_vl,
  input  logic [SV_W-1:0]          cmd_subvl,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);

  localparam int AW    = $clog2(NREGS);
  localparam int CNT_W = VL_W + SV_W;
  localparam int RW    = AW + CNT_W + 1;   // register-number sum width
  localparam int EW    = XLEN + 2;         // source-number sum width

  logic             accept, reject, sub_mode;
  logic [1:0]       wcode;
  logic [VL_W-1:0]  outer;
  logic [SV_W-1:0]  inner, sv_len;
  logic [CNT_W-1:0] step, elem, reg_off, group;
  logic [XLEN-1:0]  idx_word, idx_val, src_word;
  logic [AW-1:0]    dst_q, base_q, isrc_q;
  logic [RW-1:0]    idx_num, dst_num;
  logic [EW-1:0]    src_num;
  logic             move_ok;
  logic             rf_we;
  logic [AW-1:0]    rf_waddr;
  logic [XLEN-1:0]  rf_wdata;

  pim_sequencer #(.VL_W(VL_W), .SV_W(SV_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .fn(cmd_fn), .vl(cmd_vl),
    .subvl(cmd_subvl), .busy(busy), .done(done), .accept(accept),
    .reject(reject), .sub_mode(sub_mode), .wcode(wcode), .outer(outer),
    .inner(inner), .step(step), .sv_len(sv_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q  <= '0;
      base_q <= '0;
      isrc_q <= '0;
    end else if (accept) begin
      dst_q  <= cmd_dst;
      base_q <= cmd_base;
      isrc_q <= cmd_idx;
    end
  end

  // group mode reuses the first subvl indices for every outer group
  assign elem  = sub_mode ? CNT_W'(inner) : step;
  assign group = sub_mode ? (CNT_W'(outer) * CNT_W'(sv_len)) : '0;

  pim_index_extract #(.XLEN(XLEN), .CNT_W(CNT_W)) u_extract (
    .word(idx_word), .elem(elem), .wcode(wcode),
    .idx_val(idx_val), .reg_off(reg_off)
  );

  assign idx_num = RW'(isrc_q) + RW'(reg_off);
  assign dst_num = RW'(dst_q) + RW'(step);
  assign src_num = EW'(base_q) + EW'(group) + EW'(idx_val);
  assign move_ok = (idx_num < RW'(NREGS)) && (dst_num < RW'(NREGS))
                && (src_num < EW'(NREGS));

  always_comb begin
    if (busy) begin
      rf_we    = move_ok;
      rf_waddr = dst_num[AW-1:0];
      rf_wdata = src_word;
    end else begin
      rf_we    = load_en;
      rf_waddr = load_addr;
      rf_wdata = load_data;
    end
  end

  pim_regfile #(.XLEN(XLEN), .NREGS(NREGS), .AW(AW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .idx_addr(idx_num[AW-1:0]), .idx_data(idx_word),
    .src_addr(src_num[AW-1:0]), .src_data(src_word),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                    err <= 1'b0;
    else if (accept)            err <= reject;
    else if (busy && !move_ok)  err <= 1'b1;
  end

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ($past(busy) || $past(start)));

  assert_err_clear_on_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_fn[0]) |=> !err);

endmodule

// File: tb/packed_index_mover_bench.sv
`timescale 1ns/1ps
module packed_index_mover_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        load_en;
  logic [4:0]  load_addr;
  logic [63:0] load_data;
  logic [4:0]  peek_addr;
  logic [63:0] peek_data;
  logic        start;
  logic [4:0]  cmd_dst, cmd_base, cmd_idx;
  logic [3:0]  cmd_fn;
  logic [3:0]  cmd_vl;
  logic [2:0]  cmd_subvl;
  logic        busy, done, err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  packed_index_mover u_packed_index_mover (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .start(start), .cmd_dst(cmd_dst), .cmd_base(cmd_base), .cmd_idx(cmd_idx),
    .cmd_fn(cmd_fn), .cmd_vl(cmd_vl), .cmd_subvl(cmd_subvl),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [63:0] v(input int r);
    return 64'hC0DE_0000_0000_0000 | 64'(r);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic load(input int a, input logic [63:0] d);
    @(negedge clk);
    load_en = 1'b1; load_addr = 5'(a); load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic peek(input int a, output logic [63:0] d);
    @(negedge clk);
    peek_addr = 5'(a);
    @(negedge clk);
    d = peek_data;
  endtask

  task automatic init_regs();
    for (int r = 0; r < 32; r++) load(r, v(r));
  endtask

  task automatic expect_reg(input string req, input int a, input logic [63:0] e);
    logic [63:0] d;
    peek(a, d);
    chk(req, $sformatf("reg %0d", a), d, e);
  endtask

  // returns number of clock edges after the accepting edge until done
  task automatic run_cmd(input int dst, input int base, input int idx,
                         input logic [3:0] fn, input int vl, input int sv,
                         output int cyc);
    @(negedge clk);
    cmd_dst = 5'(dst); cmd_base = 5'(base); cmd_idx = 5'(idx);
    cmd_fn = fn; cmd_vl = 4'(vl); cmd_subvl = 3'(sv); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "err",  64'(err),  64'd0);
  endtask

  task automatic t_load_peek();
    load(5, 64'h1234_5678_9ABC_DEF0);
    expect_reg("R2", 5, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_full_width();
    int cyc;
    init_regs();
    load(10, 64'd2); load(11, 64'd0); load(12, 64'd3);
    run_cmd(1, 20, 10, 4'b0001, 3, 1, cyc);
    chk("R6", "cycles full", 64'(cyc), 64'd3);
    chk("R3", "err", 64'(err), 64'd0);
    expect_reg("R3", 1, v(22));
    expect_reg("R3", 2, v(20));
    expect_reg("R3", 3, v(23));
  endtask

  task automatic t_pack8();
    int cyc;
    logic [63:0] e [10] = '{v(3), v(0), v(1), v(2), v(4), v(5), v(6), v(7), v(6), v(5)};
    init_regs();
    load(8, 64'h0706_0504_0201_0003);
    load(9, 64'hFFFF_FFFF_FFFF_0506);
    run_cmd(22, 0, 8, 4'b0101, 10, 1, cyc);
    chk("R6", "cycles 8-bit", 64'(cyc), 64'd10);
    for (int k = 0; k < 10; k++) expect_reg("R4", 22 + k, e[k]);
  endtask

  task automatic t_pack16();
    int cyc;
    init_regs();
    load(8, 64'h0000_0007_0002_0005);
    load(9, 64'hABCD_ABCD_ABCD_0001);
    run_cmd(20, 0, 8, 4'b1001, 5, 1, cyc);
    expect_reg("R4", 20, v(5));
    expect_reg("R4", 21, v(2));
    expect_reg("R4", 22, v(7));
    expect_reg("R4", 23, v(0));
    expect_reg("R4", 24, v(1));
  endtask

  task automatic t_pack32();
    int cyc;
    init_regs();
    load(8, {32'd4, 32'd6});
    load(9, {32'hFFFF_FFFF, 32'd3});
    run_cmd(20, 0, 8, 4'b1101, 3, 1, cyc);
    expect_reg("R4", 20, v(6));
    expect_reg("R4", 21, v(4));
    expect_reg("R4", 22, v(3));
  endtask

  task automatic t_group();
    int cyc;
    init_regs();
    load(8, 64'hFFFF_FFFF_FF01_0002);
    run_cmd(24, 12, 8, 4'b0111, 2, 3, cyc);
    chk("R6", "cycles group", 64'(cyc), 64'd6);
    chk("R5", "err", 64'(err), 64'd0);
    expect_reg("R5", 24, v(14));
    expect_reg("R5", 25, v(12));
    expect_reg("R5", 26, v(13));
    expect_reg("R5", 27, v(17));
    expect_reg("R5", 28, v(15));
    expect_reg("R5", 29, v(16));
  endtask

  task automatic t_chain();
    int cyc;
    init_regs();
    load(8, 64'd2); load(9, 64'd1);
    run_cmd(4, 3, 8, 4'b0001, 2, 1, cyc);
    expect_reg("R7", 4, v(5));
    expect_reg("R7", 5, v(5));
  endtask

  task automatic t_range();
    int cyc;
    init_regs();
    load(16, 64'd1); load(17, 64'd9); load(18, 64'd2);
    run_cmd(10, 28, 16, 4'b0001, 3, 1, cyc);
    chk("R8", "cycles", 64'(cyc), 64'd3);
    chk("R8", "err set", 64'(err), 64'd1);
    expect_reg("R8", 10, v(29));
    expect_reg("R8", 11, v(11));
    expect_reg("R8", 12, v(30));
    run_cmd(0, 0, 18, 4'b0001, 1, 1, cyc);
    chk("R8", "err cleared", 64'(err), 64'd0);
    expect_reg("R8", 0, v(2));
  endtask

  task automatic t_reserved();
    int cyc;
    init_regs();
    load(8, 64'd3);
    run_cmd(0, 0, 8, 4'b0000, 2, 1, cyc);
    chk("R9", "cycles", 64'(cyc), 64'd0);
    chk("R9", "err", 64'(err), 64'd1);
    chk("R9", "busy", 64'(busy), 64'd0);
    expect_reg("R9", 0, v(0));
    expect_reg("R9", 1, v(1));
  endtask

  task automatic t_empty();
    int cyc;
    init_regs();
    load(8, 64'd3);
    run_cmd(0, 0, 8, 4'b0001, 0, 1, cyc);
    chk("R10", "cycles vl0", 64'(cyc), 64'd0);
    chk("R10", "err", 64'(err), 64'd0);
    run_cmd(0, 0, 8, 4'b0001, 2, 0, cyc);
    chk("R10", "cycles sv0", 64'(cyc), 64'd0);
    expect_reg("R10", 0, v(0));
  endtask

  task automatic t_busy_ignore();
    int cyc;
    init_regs();
    for (int k = 0; k < 8; k++) load(16 + k, 64'(k));
    @(negedge clk);
    cmd_dst = 5'd0; cmd_base = 5'd8; cmd_idx = 5'd16;
    cmd_fn = 4'b0001; cmd_vl = 4'd8; cmd_subvl = 3'd1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_en = 1'b1; load_addr = 5'd30; load_data = 64'hDEAD_BEEF_DEAD_BEEF;
    cmd_dst = 5'd30; cmd_base = 5'd0; cmd_vl = 4'd1;
    @(posedge clk);
    @(negedge clk);
    load_en = 1'b0; start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    chk("R11", "cycles", 64'(cyc), 64'd8);
    repeat (3) @(negedge clk);
    chk("R11", "no restart busy", 64'(busy), 64'd0);
    chk("R11", "no restart done", 64'(done), 64'd0);
    expect_reg("R11", 30, v(30));
    expect_reg("R11", 0, v(8));
    expect_reg("R11", 7, v(15));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    rst = 1'b1; load_en = 1'b0; load_addr = '0; load_data = '0;
    peek_addr = '0; start = 1'b0; cmd_dst = '0; cmd_base = '0;
    cmd_idx = '0; cmd_fn = '0; cmd_vl = '0; cmd_subvl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_peek();
    t_full_width();
    t_pack8();
    t_pack16();
    t_pack32();
    t_group();
    t_chain();
    t_range();
    t_reserved();
    t_empty();
    t_busy_ignore();
    report();
  end

endmodule